// File: doc/BRIEF.md
# Protected-Mode Segment Register Loader

This block fills one segment register of a protected-mode address unit. A load request carries a 16-bit selector and the current privilege level. The selector is split into a 13-bit table index, a table-select bit and a requested privilege level. The block then reads the 8-byte descriptor from the global or the local descriptor table over a simple request/acknowledge memory port. It checks that the segment is present and that the privilege levels allow the load. If both checks pass, it writes the descriptor's upper word back with the accessed flag set, and stores the base, the expanded limit and the attributes in a hidden cache.

After a load, each translation request uses only the cache. The offset is bound-checked against the cached limit, in the reversed sense for expand-down data segments, and added to the cached base. The descriptor table is not read again. Each load ends in exactly one of three single-cycle pulses: done, not-present fault or privilege fault.

Top module: `seg_loader`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 selects the table (0 global, 1 local) and bits 1:0 are the requested level. The descriptor's lower word is read at table base + index*8 and its upper word at that address + 4. A request holds its address stable until it is acknowledged.
- R2: If the upper word's present bit (bit 15) is 0, the load ends with a one-cycle `np_fault`. Nothing is written back and the cache is left unchanged. This fault has priority over the privilege fault.
- R3: If max(CPL, RPL) is numerically greater than the descriptor level (upper bits 14:13), the load ends with a one-cycle `priv_fault`. Nothing is written back and the cache is left unchanged.
- R4: On a successful load, the upper word is written back to its own address with bit 8 (accessed) set. `load_done` pulses for one cycle, in the cycle after that write is acknowledged.
- R5: The limit is {upper 19:16, lower 15:0}. If upper bit 23 is 1, it is expanded to {limit, 12'hFFF}. Otherwise it is zero-extended.
- R6: A translation request makes `lin_valid` high in the next cycle, with `lin_addr` = cached base + offset modulo 2^32. The base is {upper 31:24, upper 7:0, lower 31:16}.
- R7: For a normal segment, an offset greater than the effective limit raises `limit_fault` together with `lin_valid`. An offset equal to the limit does not.
- R8: A segment is expand-down when upper bit 12 = 1, bit 11 = 0 and bit 10 = 1. For such a segment, offsets at or below the limit fault, and offsets above it up to 0xFFFFFFFF are valid.
- R9: Before the first successful load, every translation raises `limit_fault`. A failed load keeps the earlier cache in effect.
- R10: `load_done`, `np_fault` and `priv_fault` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Start a load (taken when idle) |
| selector | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global descriptor table base |
| ldt_base | input | ADDR_W | Local descriptor table base |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| busy | output | 1 | Load in progress |
| load_done | output | 1 | Successful load pulse |
| np_fault | output | 1 | Segment-not-present pulse |
| priv_fault | output | 1 | Privilege violation pulse |
| xlat_req | input | 1 | Translation request |
| xlat_off | input | 32 | Offset to translate |
| lin_valid | output | 1 | Translation result valid |
| lin_addr | output | 32 | Linear address |
| limit_fault | output | 1 | Offset outside segment |

## Verification
Loads are exercised from both tables. The descriptors are chosen to separate presence from privilege: P=0 combined with a bad level shows that the presence check has priority, and an RPL above the CPL shows that the larger of the two levels is the one compared. Translations use offsets at the limit, one past the limit, zero and a random value, on byte-granular, page-granular and expand-down segments, so an off-by-one or a reversed bound shows up. A stretch of random descriptors and levels, checked by a bench-side cache model, shows that a failed load never disturbs the segment already loaded.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CHECK, ST_WB
  } ld_state_t;

  typedef struct packed {
    logic        valid;
    logic [31:0] base;
    logic [31:0] limit;
    logic        expdown;
    logic [1:0]  dpl;
    logic        dflt32;
    logic [3:0]  kind;
  } seg_cache_t;

  localparam int ACC_BIT  = 8;
  localparam int PRES_BIT = 15;
  localparam int GRAN_BIT = 23;
endpackage

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
(
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  input  logic [1:0]  cur_pl,
  input  logic [1:0]  req_pl,
  output logic        present,
  output logic        priv_ok,
  output seg_cache_t  new_cache
);
  logic [19:0] raw_lim;
  logic [1:0]  eff_pl;
  logic [1:0]  dpl;

  always_comb begin
    raw_lim = {hi_word[19:16], lo_word[15:0]};
    dpl     = hi_word[14:13];
    eff_pl  = (cur_pl > req_pl) ? cur_pl : req_pl;
    present = hi_word[PRES_BIT];
    priv_ok = (eff_pl <= dpl);
    new_cache.valid   = 1'b1;
    new_cache.base    = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    new_cache.limit   = hi_word[GRAN_BIT] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
    new_cache.expdown = hi_word[12] & ~hi_word[11] & hi_word[10];
    new_cache.dpl     = dpl;
    new_cache.dflt32  = hi_word[22];
    new_cache.kind    = hi_word[11:8];
  end
endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       lo_word,
  output logic [31:0]       hi_word,
  output logic [1:0]        cur_pl,
  output logic [1:0]        req_pl,
  input  logic              present,
  input  logic              priv_ok,
  input  seg_cache_t        new_cache,
  output seg_cache_t        cache,
  output logic              busy,
  output logic              load_done,
  output logic              np_fault,
  output logic              priv_fault
);
  localparam int IDX_W = 13;

  ld_state_t         state;
  logic [ADDR_W-1:0] desc_addr;
  logic [15:0]       sel_q;
  logic [ADDR_W-1:0] tbl_base;

  assign tbl_base = selector[2] ? ldt_base : gdt_base;
  assign req_pl   = sel_q[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      desc_addr  <= '0;
      sel_q      <= '0;
      cur_pl     <= '0;
      lo_word    <= '0;
      hi_word    <= '0;
      cache      <= '0;
      load_done  <= 1'b0;
      np_fault   <= 1'b0;
      priv_fault <= 1'b0;
    end else begin
      load_done  <= 1'b0;
      np_fault   <= 1'b0;
      priv_fault <= 1'b0;
      unique case (state)
        ST_IDLE: if (load_req) begin
          sel_q     <= selector;
          cur_pl    <= cpl;
          desc_addr <= tbl_base + ADDR_W'({selector[15:16-IDX_W], 3'b000});
          state     <= ST_RD_LO;
        end
        ST_RD_LO: if (mem_ack) begin
          lo_word <= mem_rdata;
          state   <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ack) begin
          hi_word <= mem_rdata;
          state   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!present) begin
            np_fault <= 1'b1;
            state    <= ST_IDLE;
          end else if (!priv_ok) begin
            priv_fault <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            state <= ST_WB;
          end
        end
        ST_WB: if (mem_ack) begin
          cache     <= new_cache;
          load_done <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == ST_RD_LO) || (state == ST_RD_HI) || (state == ST_WB);
    mem_we    = (state == ST_WB);
    mem_addr  = (state == ST_RD_LO) ? desc_addr : desc_addr + ADDR_W'(4);
    mem_wdata = hi_word | (32'd1 << ACC_BIT);
    busy      = (state != ST_IDLE);
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  seg_cache_t  cache,
  input  logic        xlat_req,
  input  logic [31:0] xlat_off,
  output logic        lin_valid,
  output logic [31:0] lin_addr,
  output logic        limit_fault
);
  logic outside;

  always_comb begin
    if (!cache.valid)       outside = 1'b1;
    else if (cache.expdown) outside = (xlat_off <= cache.limit);
    else                    outside = (xlat_off > cache.limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lin_valid   <= 1'b0;
      lin_addr    <= '0;
      limit_fault <= 1'b0;
    end else begin
      lin_valid   <= xlat_req;
      limit_fault <= xlat_req & outside;
      if (xlat_req) lin_addr <= cache.base + xlat_off;
    end
  end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              load_done,
  output logic              np_fault,
  output logic              priv_fault,
  input  logic              xlat_req,
  input  logic [31:0]       xlat_off,
  output logic              lin_valid,
  output logic [31:0]       lin_addr,
  output logic              limit_fault
);
  logic [31:0] lo_word, hi_word;
  logic [1:0]  cur_pl, req_pl;
  logic        present, priv_ok;
  seg_cache_t  new_cache, cache;

  seg_load_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .load_req(load_req), .selector(selector), .cpl(cpl),
    .gdt_base(gdt_base), .ldt_base(ldt_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lo_word(lo_word), .hi_word(hi_word), .cur_pl(cur_pl), .req_pl(req_pl),
    .present(present), .priv_ok(priv_ok), .new_cache(new_cache), .cache(cache),
    .busy(busy), .load_done(load_done), .np_fault(np_fault), .priv_fault(priv_fault)
  );

  seg_desc_check u_chk (
    .lo_word(lo_word), .hi_word(hi_word), .cur_pl(cur_pl), .req_pl(req_pl),
    .present(present), .priv_ok(priv_ok), .new_cache(new_cache)
  );

  seg_xlat u_xlat (
    .clk(clk), .rst(rst), .cache(cache), .xlat_req(xlat_req), .xlat_off(xlat_off),
    .lin_valid(lin_valid), .lin_addr(lin_addr), .limit_fault(limit_fault)
  );
endmodule

// File: rtl/seg_loader_sva.sv
module seg_loader_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              load_done,
  input logic              np_fault,
  input logic              priv_fault,
  input logic              xlat_req,
  input logic              lin_valid,
  input logic              limit_fault
);
  p_outcome_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_done, np_fault, priv_fault}));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    load_done |=> !load_done);

  p_done_after_wb_r4: assert property (@(posedge clk) disable iff (rst)
    load_done |-> $past(mem_req && mem_we && mem_ack));

  p_wb_accessed_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[8]);

  p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_lin_latency_r6: assert property (@(posedge clk) disable iff (rst)
    lin_valid |-> $past(xlat_req));

  p_fault_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
    limit_fault |-> lin_valid);
endmodule

bind seg_loader seg_loader_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .load_done(load_done),
  .np_fault(np_fault), .priv_fault(priv_fault), .xlat_req(xlat_req),
  .lin_valid(lin_valid), .limit_fault(limit_fault)
);

// File: tb/test_seg_loader.sv
module test_seg_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_req = 1'b0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic [31:0] gdt_base = 32'h0000_0000;
  logic [31:0] ldt_base = 32'h0000_0200;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        busy, load_done, np_fault, priv_fault;
  logic        xlat_req = 1'b0;
  logic [31:0] xlat_off = '0;
  logic        lin_valid, limit_fault;
  logic [31:0] lin_addr;

  int total = 0;
  int bad   = 0;

  logic [31:0] mem [256];
  logic [31:0] rd_last = '0, rd_prev = '0;

  logic        m_valid = 1'b0;
  logic [31:0] m_base = '0, m_lim = '0;
  logic        m_ed = 1'b0;

  always #4 clk = ~clk;

  seg_loader i_seg_loader (
    .clk(clk), .rst(rst), .load_req(load_req), .selector(selector), .cpl(cpl),
    .gdt_base(gdt_base), .ldt_base(ldt_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
    .load_done(load_done), .np_fault(np_fault), .priv_fault(priv_fault),
    .xlat_req(xlat_req), .xlat_off(xlat_off), .lin_valid(lin_valid),
    .lin_addr(lin_addr), .limit_fault(limit_fault)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else begin
          mem_rdata = mem[mem_addr[9:2]];
          rd_prev   = rd_last;
          rd_last   = mem_addr;
        end
      end else mem_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(logic [31:0] b, logic [19:0] l, bit g, bit p,
                                        logic [1:0] dpl, bit s, logic [3:0] t);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], p, dpl, s, t, b[23:16]};
  endfunction

  function automatic logic [31:0] mk_lo(logic [31:0] b, logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction

  function automatic int exp_outcome(logic [31:0] hi, logic [1:0] c, logic [1:0] r);
    logic [1:0] e;
    e = (c > r) ? c : r;
    if (!hi[15]) return 2;
    if (e > hi[14:13]) return 3;
    return 1;
  endfunction

  function automatic logic [31:0] exp_limit(logic [31:0] lo, logic [31:0] hi);
    logic [19:0] l;
    l = {hi[19:16], lo[15:0]};
    return hi[23] ? {l, 12'hFFF} : {12'h0, l};
  endfunction

  function automatic bit exp_fault(logic [31:0] off);
    if (!m_valid) return 1'b1;
    if (m_ed) return off <= m_lim;
    return off > m_lim;
  endfunction

  task automatic put_desc(input bit ti, input int idx, input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] a;
    a = (ti ? ldt_base : gdt_base) + 32'(idx * 8);
    mem[a[9:2]]     = lo;
    mem[a[9:2] + 1] = hi;
  endtask

  task automatic do_load(input bit ti, input int idx, input logic [1:0] r, input logic [1:0] c, input string tag);
    logic [31:0] a, lo, hi;
    int got, want, n;
    a  = (ti ? ldt_base : gdt_base) + 32'(idx * 8);
    lo = mem[a[9:2]];
    hi = mem[a[9:2] + 1];
    want = exp_outcome(hi, c, r);
    @(negedge clk);
    selector = {13'(idx), ti, r};
    cpl      = c;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    got = 0;
    n = 0;
    while (got == 0 && n < 60) begin
      @(negedge clk);
      n++;
      if (load_done) got = 1;
      else if (np_fault) got = 2;
      else if (priv_fault) got = 3;
    end
    chk(got == want, {tag, " R2/R3 outcome"}, 32'(got), 32'(want));
    chk(rd_prev == a && rd_last == a + 4, {tag, " R1 read addresses"}, rd_prev, a);
    if (want == 1) begin
      chk(mem[a[9:2] + 1] == (hi | 32'h100), {tag, " R4 accessed write-back"}, mem[a[9:2] + 1], hi | 32'h100);
      m_valid = 1'b1;
      m_base  = {hi[31:24], hi[7:0], lo[31:16]};
      m_lim   = exp_limit(lo, hi);
      m_ed    = hi[12] & ~hi[11] & hi[10];
    end else begin
      chk(mem[a[9:2] + 1] == hi, {tag, " R2 no write on fault"}, mem[a[9:2] + 1], hi);
    end
    @(negedge clk);
    chk(!load_done && !np_fault && !priv_fault, {tag, " R10 single pulse"},
        {29'd0, load_done, np_fault, priv_fault}, 32'd0);
  endtask

  task automatic do_xlat(input logic [31:0] off, input string tag);
    logic [31:0] ea;
    bit ef;
    ea = m_base + off;
    ef = exp_fault(off);
    @(negedge clk);
    xlat_req = 1'b1;
    xlat_off = off;
    @(negedge clk);
    xlat_req = 1'b0;
    chk(lin_valid, {tag, " R6 valid next cycle"}, 32'(lin_valid), 32'd1);
    chk(limit_fault == ef, {tag, " R7/R8/R9 limit fault"}, 32'(limit_fault), 32'(ef));
    if (m_valid) chk(lin_addr == ea, {tag, " R6 linear address"}, lin_addr, ea);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !load_done && !lin_valid, "reset state R10", {28'd0, busy, mem_req, load_done, lin_valid}, 32'd0);

    do_xlat(32'h0, "R9 no segment");

    put_desc(0, 3, mk_lo(32'h1234_5678, 20'h00FFF), mk_hi(32'h1234_5678, 20'h00FFF, 0, 1, 2'd3, 1, 4'h2));
    do_load(0, 3, 2'd0, 2'd0, "byte seg");
    do_xlat(32'h0000_0FFF, "R7 at limit");
    do_xlat(32'h0000_1000, "R7 past limit");
    do_xlat(32'h0000_0010, "R6 add");

    put_desc(1, 5, mk_lo(32'hA000_0000, 20'h00002), mk_hi(32'hA000_0000, 20'h00002, 1, 1, 2'd2, 1, 4'hA));
    do_load(1, 5, 2'd1, 2'd2, "R5 page seg");
    do_xlat(32'h0000_2FFF, "R5 page limit");
    do_xlat(32'h0000_3000, "R5 page past");

    put_desc(0, 7, mk_lo(32'h0040_0000, 20'h00FFF), mk_hi(32'h0040_0000, 20'h00FFF, 0, 1, 2'd0, 1, 4'h6));
    do_load(0, 7, 2'd0, 2'd0, "R8 expand-down");
    do_xlat(32'h0000_0FFF, "R8 at limit");
    do_xlat(32'h0000_1000, "R8 above limit");
    do_xlat(32'hFFFF_FFFF, "R8 top");

    put_desc(1, 2, mk_lo(32'h0, 20'hFFFFF), mk_hi(32'h0, 20'hFFFFF, 1, 0, 2'd3, 1, 4'h2));
    do_load(1, 2, 2'd0, 2'd0, "R2 not present");
    do_xlat(32'h0000_1000, "R9 cache kept");

    put_desc(0, 9, mk_lo(32'h0, 20'hFFFFF), mk_hi(32'h0, 20'hFFFFF, 1, 1, 2'd1, 1, 4'h2));
    do_load(0, 9, 2'd2, 2'd0, "R3 rpl above dpl");
    do_load(0, 9, 2'd0, 2'd2, "R3 cpl above dpl");
    do_load(0, 9, 2'd1, 2'd1, "R3 equal ok");

    put_desc(0, 10, mk_lo(32'h0, 20'h1), mk_hi(32'h0, 20'h1, 0, 0, 2'd0, 1, 4'h2));
    do_load(0, 10, 2'd3, 2'd3, "R2 priority");

    for (int k = 0; k < 30; k++) begin
      bit          ti;
      int          idx;
      logic [31:0] b;
      logic [19:0] l;
      logic [3:0]  t;
      ti  = 1'($urandom);
      idx = int'($urandom % 16);
      b   = $urandom;
      l   = 20'($urandom);
      t   = 4'($urandom);
      put_desc(ti, idx, mk_lo(b, l),
               mk_hi(b, l, 1'($urandom), ($urandom % 8) != 0, 2'($urandom), 1'($urandom), t & 4'hE));
      do_load(ti, idx, 2'($urandom), 2'($urandom), "rand");
      do_xlat(m_lim, "rand limit");
      do_xlat(m_lim + 1, "rand past");
      do_xlat($urandom, "rand off");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R10 actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule